// File: doc/BRIEF.md
# Paired Channel Double-Rate Output Interleaver

This block sits at the receive side of a multi-channel link and shares one 10-bit output bus between two channels. The channels are grouped in fixed pairs: channel 2p and channel 2p+1 both drive bus p. Each word carries 8 data bits, a control flag and a spare bit. The block forwards a clock at half its own clock rate. The odd channel of a pair is placed on the bus while the forwarded clock is high, and the even channel is placed there while it is low. A complementary copy of the forwarded clock is also driven. A receiver can therefore latch the odd channel on the rising edge and the even channel on the falling edge.

The block runs on a single clock at twice the forwarded rate, and a phase toggle selects the slot. One word per channel is accepted in each forwarded period. The input side is a valid/ready stream and the ready pin is shared by all channels. Ready is high in exactly one of the two fast cycles of a period, which is the cycle before the forwarded clock rises. A word is taken only when valid and ready are both high in the same cycle; outside those cycles the inputs are not looked at. The block never stalls and has no back-pressure beyond this slot rule. A producer that has no word holds valid low in the ready cycle, and the block then fills that channel's slot with an idle control word.

Top module: `ddr_pair_interleaver`

## Requirements
- R1: While reset is high, every bus is 0, the forwarded clock is 0, its complement is 1 and ready is 0.
- R2: After reset is released, the forwarded clock toggles on every clock edge and its first change is to 1. The complement is always the inverse of the forwarded clock.
- R3: Ready is high exactly in the cycles where the forwarded clock is low and reset is low. It therefore alternates, starting high in the first cycle after reset.
- R4: In the cycle that follows an accepting cycle, the forwarded clock is high and bus p carries the word that channel 2p+1 presented in the accepting cycle.
- R5: In the cycle after that, the forwarded clock is low and bus p carries the word that channel 2p presented in the same accepting cycle.
- R6: A channel whose valid is low in the accepting cycle gets the idle word in its slot. The idle word has bit 9 = 0, bit 8 (the control flag) = 1 and bits 7:0 = the idle code input sampled in the accepting cycle.
- R7: Word layout: bits 7:0 are data, bit 8 is the control flag and bit 9 is spare. All 10 bits of a valid word reach the bus unchanged.
- R8: Words, valids and the idle code presented in a cycle where ready is low have no effect on the bus.
- R9: The pairs are independent of each other: bus p depends only on channels 2p and 2p+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate clock |
| rst_i | input | 1 | Synchronous reset, active high |
| idle_code_i | input | 8 | Control character placed in an empty slot |
| ch_word_i | input | 2*NUM_PAIRS*10 | Channel words; channel c occupies bits [c*10 +: 10] |
| ch_valid_i | input | 2*NUM_PAIRS | Per-channel valid |
| ready_o | output | 1 | Accept strobe shared by all channels |
| bus_o | output | NUM_PAIRS*10 | Shared buses; pair p occupies bits [p*10 +: 10] |
| fclk_o | output | 1 | Forwarded clock |
| fclk_n_o | output | 1 | Complement of the forwarded clock |

## Verification
The bench builds the block with NUM_PAIRS = 2, so four channels feed two buses. With this setting the independence of the pairs can be seen, and every combination of the four valid bits is reached. A sweep of 256 accepting periods steps each channel's data through all 256 byte values. It also drives both values of the control flag and of the spare bit, and changes the idle code in every period. In each non-ready cycle the bench drives conflicting words, valids and idle codes, so any leak from those cycles changes the even-channel slot.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int DATA_W = 8;
  localparam int WORD_W = DATA_W + 2;
  localparam int KFLAG_BIT = DATA_W;

  typedef logic [WORD_W-1:0] word_t;

  function automatic word_t idle_word(input logic [DATA_W-1:0] code);
    idle_word = {1'b0, 1'b1, code};
  endfunction
endpackage

// File: rtl/ilv_phase_gen.sv
module ilv_phase_gen (
  input  logic clk_i,
  input  logic rst_i,
  output logic fclk_o,
  output logic fclk_n_o,
  output logic take_o
);
  logic hi_q;
  logic lo_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hi_q <= 1'b0;
      lo_q <= 1'b1;
    end else begin
      hi_q <= ~hi_q;
      lo_q <= hi_q;
    end
  end

  assign fclk_o   = hi_q;
  assign fclk_n_o = lo_q;
  assign take_o   = ~hi_q & ~rst_i;

  assert_reset_clk_R1: assert property (@(posedge clk_i)
    rst_i |=> (!hi_q && lo_q));
  assert_clk_comp_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    lo_q == !hi_q);
  assert_toggle_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) |-> hi_q != $past(hi_q));
  assert_ready_alt_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    take_o |=> !take_o);
endmodule

// File: rtl/ilv_lane.sv
module ilv_lane
  import ilv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              take_i,
  input  logic [DATA_W-1:0] idle_code_i,
  input  word_t             word_a_i,
  input  logic              valid_a_i,
  input  word_t             word_b_i,
  input  logic              valid_b_i,
  output word_t             bus_o
);
  word_t eff_a;
  word_t eff_b;
  word_t hold_a_q;
  word_t bus_q;

  always_comb begin
    eff_a = valid_a_i ? word_a_i : idle_word(idle_code_i);
    eff_b = valid_b_i ? word_b_i : idle_word(idle_code_i);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      hold_a_q <= '0;
    end else if (take_i) begin
      hold_a_q <= eff_a;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      bus_q <= '0;
    end else if (take_i) begin
      bus_q <= eff_b;
    end else begin
      bus_q <= hold_a_q;
    end
  end

  assign bus_o = bus_q;

  assert_reset_bus_R1: assert property (@(posedge clk_i)
    rst_i |=> bus_q == '0);
  assert_odd_slot_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (take_i && valid_b_i) |=> bus_q == $past(word_b_i));
  assert_even_slot_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (take_i && valid_a_i) |=> ##1 bus_q == $past(word_a_i, 2));
  assert_idle_fill_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (take_i && !valid_a_i) |=> ##1 bus_q == {2'b01, $past(idle_code_i, 2)});
endmodule

// File: rtl/ddr_pair_interleaver.sv
module ddr_pair_interleaver
  import ilv_pkg::*;
#(
  parameter int NUM_PAIRS = 2,
  localparam int NCH = 2 * NUM_PAIRS
) (
  input  logic                          clk_i,
  input  logic                          rst_i,
  input  logic [DATA_W-1:0]             idle_code_i,
  input  logic [NCH*WORD_W-1:0]         ch_word_i,
  input  logic [NCH-1:0]                ch_valid_i,
  output logic                          ready_o,
  output logic [NUM_PAIRS*WORD_W-1:0]   bus_o,
  output logic                          fclk_o,
  output logic                          fclk_n_o
);
  logic take;

  ilv_phase_gen u_phase (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .fclk_o   (fclk_o),
    .fclk_n_o (fclk_n_o),
    .take_o   (take)
  );

  assign ready_o = take;

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam int CH_A = 2 * p;
    localparam int CH_B = 2 * p + 1;
    word_t lane_bus;

    ilv_lane u_lane (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .take_i      (take),
      .idle_code_i (idle_code_i),
      .word_a_i    (ch_word_i[CH_A*WORD_W +: WORD_W]),
      .valid_a_i   (ch_valid_i[CH_A]),
      .word_b_i    (ch_word_i[CH_B*WORD_W +: WORD_W]),
      .valid_b_i   (ch_valid_i[CH_B]),
      .bus_o       (lane_bus)
    );

    assign bus_o[p*WORD_W +: WORD_W] = lane_bus;
  end
endmodule

// File: tb/tb_ddr_pair_interleaver.sv
module tb_ddr_pair_interleaver;
  localparam int NP = 2;
  localparam int NC = 2 * NP;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [7:0]       idle_code = '0;
  logic [NC*10-1:0] ch_word = '0;
  logic [NC-1:0]    ch_valid = '0;
  logic             ready;
  logic [NP*10-1:0] bus;
  logic             fclk;
  logic             fclk_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ddr_pair_interleaver #(.NUM_PAIRS(NP)) dut (
    .clk_i       (clk),
    .rst_i       (rst),
    .idle_code_i (idle_code),
    .ch_word_i   (ch_word),
    .ch_valid_i  (ch_valid),
    .ready_o     (ready),
    .bus_o       (bus),
    .fclk_o      (fclk),
    .fclk_n_o    (fclk_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] mk_word(input int i, input int c);
    logic [7:0] d;
    logic k, s;
    d = 8'((i * 7 + c * 53) % 256);
    k = 1'(((i >> 4) & 1) ^ (c & 1));
    s = 1'(((i >> 5) & 1) ^ ((c >> 1) & 1));
    return {s, k, d};
  endfunction

  logic [9:0] exp_w [NC];

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: state held during reset
    chk(bus == '0, "R1 bus", 32'(bus), 0);
    chk(fclk == 1'b0, "R1 fclk", 32'(fclk), 0);
    chk(fclk_n == 1'b1, "R1 fclk_n", 32'(fclk_n), 1);
    chk(ready == 1'b0, "R1 ready", 32'(ready), 0);
    rst = 1'b0;
    #1;
    chk(ready == 1'b1, "R3 first ready", 32'(ready), 1);

    for (int i = 0; i < 256; i++) begin
      // accepting cycle
      chk(ready == 1'b1, "R3 ready high in low phase", 32'(ready), 1);
      chk(fclk == 1'b0 && fclk_n == 1'b1, "R2 low phase", {fclk, fclk_n}, 2'b01);
      idle_code = 8'((i * 13 + 5) % 256);
      for (int c = 0; c < NC; c++) begin
        ch_word[c*10 +: 10] = mk_word(i, c);
        ch_valid[c] = 1'((i >> c) & 1);
        exp_w[c] = ch_valid[c] ? mk_word(i, c) : {2'b01, idle_code};
      end
      @(negedge clk);
      chk(fclk == 1'b1 && fclk_n == 1'b0, "R2 high phase", {fclk, fclk_n}, 2'b10);
      chk(ready == 1'b0, "R3 ready low in high phase", 32'(ready), 0);
      for (int p = 0; p < NP; p++)
        chk(bus[p*10 +: 10] == exp_w[2*p+1], "R4 R6 R7 R9 odd slot",
            32'(bus[p*10 +: 10]), 32'(exp_w[2*p+1]));
      // R8: disturb inputs while ready is low
      idle_code = ~idle_code;
      ch_valid = '1;
      for (int c = 0; c < NC; c++) ch_word[c*10 +: 10] = ~mk_word(i, c);
      @(negedge clk);
      chk(fclk == 1'b0, "R2 fall", 32'(fclk), 0);
      for (int p = 0; p < NP; p++)
        chk(bus[p*10 +: 10] == exp_w[2*p], "R5 R6 R8 R9 even slot",
            32'(bus[p*10 +: 10]), 32'(exp_w[2*p]));
    end

    rst = 1'b1;
    @(negedge clk);
    chk(bus == '0 && fclk == 1'b0 && fclk_n == 1'b1 && ready == 1'b0, "R1 re-reset",
        {bus, fclk, fclk_n, ready}, 32'b0010);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule